// File: doc/BRIEF.md
# DMA Status and Interrupt Controller

This block gathers the event pulses of a packet DMA engine into a sticky status word of seventeen bits. Software reads the word over a simple CSR port and clears bits by writing ones to them. A second word holds one enable bit per status bit. The registered OR of the enabled status bits drives a single interrupt line.

Bit 6 marks a finished receive. It can also be set late by a receive watchdog. When the watchdog reload value is non-zero, a frame that arrives without immediate completion (`rx_frame_i`) starts a countdown. When the countdown runs out, bit 6 is set. A direct receive-done event on bit 6 cancels the countdown.

The watchdog is a two-state machine:
- **WD_IDLE** moves to **WD_COUNT** on ARM: `rx_frame_i` while the reload value is non-zero.
- **WD_COUNT** stays in **WD_COUNT** on RELOAD: a further `rx_frame_i` reloads the count.
- **WD_COUNT** moves to **WD_IDLE** on EXPIRE: the count is zero, and this sets bit 6.
- Any state moves to **WD_IDLE** on CANCEL. CANCEL is caused by a software reset, a bit-6 event or a zero reload value.

The priority, highest first, is: software reset, bit-6 event, zero reload, frame, expiry.

CSR map, selected by `csr_addr`:
- 0: the status word (write one to clear).
- 1: the enable word.
- 2: the watchdog reload value.
- 3: reserved, reads as zero.

Top module: `dma_irq_ctrl`

## Requirements
- R1: An event pulse on `evt_i[k]` sets status bit k at the next clock edge. The bit then stays set across any number of reads and idle cycles.
- R2: A CSR write to address 0 clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are unchanged, and write-data bits 31:17 are ignored.
- R3: When an event and a write-one-clear hit the same status bit in the same cycle, the bit stays set.
- R4: The enable word at address 1 holds one bit per status bit. It is 0 after hardware reset and reads back what was written, masked to bits 16:0.
- R5: `irq_o` equals the OR over k of (status[k] AND enable[k]), delayed by one register. A status bit whose enable is 0 never raises `irq_o`.
- R6: With a non-zero reload value N at address 2, an `rx_frame_i` pulse sampled at edge E0 sets status bit 6 at edge E0+N+1, and not before.
- R7: With a reload value of 0, `rx_frame_i` never sets status bit 6.
- R8: An `evt_i[6]` pulse during a countdown stops the countdown, and no later expiry sets bit 6.
- R9: `soft_rst` clears the status word, the enable word and `irq_o` at the next edge, and stops the countdown. The reload value is kept.
- R10: Address 2 reads back the reload value masked to its 8 bits, and address 3 reads as zero.
- R11: An `rx_frame_i` pulse during a countdown restarts it, so the expiry falls N+1 edges after the latest pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset |
| evt_i | input | 17 | Single-cycle event pulses, one per status bit |
| rx_frame_i | input | 1 | Frame received without immediate completion; arms the watchdog |
| csr_wr | input | 1 | CSR write strobe |
| csr_addr | input | 2 | CSR word select |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data, combinational from `csr_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
Each result has a fixed delay after its stimulus:
- Status bits, enable bits and the reload value are visible on the combinational read port one edge after the event or write.
- `irq_o` follows one edge after that.
- A bit-6 expiry lands N+1 edges after the edge that sampled `rx_frame_i`.

The bench drives all inputs just after a rising edge and reads `csr_rdata` a fraction of a nanosecond later. Every check therefore samples a state reached by a counted number of edges. In the countdown sweeps the bench checks bit 6 at every edge, so an early expiry is reported as well as a late one.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int NUM_EVT     = 17;
    localparam int RX_DONE_BIT = 6;
    localparam int CSR_DW      = 32;
    localparam int CSR_AW      = 2;

    typedef enum logic [CSR_AW-1:0] {
        CSR_STATUS = 2'd0,
        CSR_ENABLE = 2'd1,
        CSR_WDOG   = 2'd2,
        CSR_RSVD   = 2'd3
    } csr_sel_e;

    typedef enum logic {
        WD_IDLE  = 1'b0,
        WD_COUNT = 1'b1
    } wd_state_e;
endpackage

// File: rtl/dma_status_bank.sv
module dma_status_bank #(
    parameter int N = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o
);
    // One sticky flop per bit; a set in the same cycle beats a clear.
    for (genvar k = 0; k < N; k++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (soft_rst)
                bit_q <= 1'b0;
            else if (set_i[k])
                bit_q <= 1'b1;
            else if (clr_i[k])
                bit_q <= 1'b0;
        end
        assign status_o[k] = bit_q;
    end
endmodule

// File: rtl/dma_rx_watchdog.sv
module dma_rx_watchdog
    import dma_irq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] limit_i,
    input  logic         frame_i,
    input  logic         rx_done_i,
    output logic         expire_o,
    output logic         busy_o
);
    wd_state_e    state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         enabled;

    assign enabled = (limit_i != '0);

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state and output process
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (soft_rst) begin
            state_d = WD_IDLE;
            cnt_d   = '0;
        end else if (rx_done_i) begin
            state_d = WD_IDLE;
            cnt_d   = limit_i;
        end else if (!enabled) begin
            state_d = WD_IDLE;
        end else begin
            unique case (state_q)
                WD_IDLE: begin
                    if (frame_i) begin
                        state_d = WD_COUNT;
                        cnt_d   = limit_i;
                    end
                end
                WD_COUNT: begin
                    if (frame_i) begin
                        cnt_d = limit_i;
                    end else if (cnt_q == '0) begin
                        expire_o = 1'b1;
                        state_d  = WD_IDLE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: state_d = WD_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q == WD_COUNT);
endmodule

// File: rtl/dma_irq_gate.sv
module dma_irq_gate #(
    parameter int N = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [N-1:0] status_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);
    logic irq_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (soft_rst)
            irq_q <= 1'b0;
        else
            irq_q <= |(status_i & en_i);
    end
    assign irq_o = irq_q;
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dma_irq_pkg::*;
#(
    parameter int WDOG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [16:0]       evt_i,
    input  logic              rx_frame_i,
    input  logic              csr_wr,
    input  logic [1:0]        csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              irq_o
);
    logic [NUM_EVT-1:0] status_q, en_q, set_vec, clr_vec;
    logic [WDOG_W-1:0]  limit_q;
    logic               wd_expire, wd_busy;
    csr_sel_e           sel;

    assign sel = csr_sel_e'(csr_addr);

    always_comb begin
        set_vec = evt_i;
        set_vec[RX_DONE_BIT] = evt_i[RX_DONE_BIT] | wd_expire;
        clr_vec = (csr_wr && sel == CSR_STATUS) ? csr_wdata[NUM_EVT-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            limit_q <= '0;
        end else begin
            if (soft_rst)
                en_q <= '0;
            else if (csr_wr && sel == CSR_ENABLE)
                en_q <= csr_wdata[NUM_EVT-1:0];
            if (csr_wr && sel == CSR_WDOG)
                limit_q <= csr_wdata[WDOG_W-1:0];
        end
    end

    dma_status_bank #(.N(NUM_EVT)) u_bank (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .set_i(set_vec), .clr_i(clr_vec), .status_o(status_q)
    );

    dma_rx_watchdog #(.W(WDOG_W)) u_wdog (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .limit_i(limit_q), .frame_i(rx_frame_i),
        .rx_done_i(evt_i[RX_DONE_BIT]),
        .expire_o(wd_expire), .busy_o(wd_busy)
    );

    dma_irq_gate #(.N(NUM_EVT)) u_gate (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .status_i(status_q), .en_i(en_q), .irq_o(irq_o)
    );

    always_comb begin
        csr_rdata = '0;
        unique case (sel)
            CSR_STATUS: csr_rdata[NUM_EVT-1:0] = status_q;
            CSR_ENABLE: csr_rdata[NUM_EVT-1:0] = en_q;
            CSR_WDOG:   csr_rdata[WDOG_W-1:0]  = limit_q;
            CSR_RSVD:   csr_rdata = '0;
            default:    csr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk #(
    parameter int N = 17,
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         soft_rst,
    input logic [N-1:0] evt,
    input logic         expire,
    input logic         csr_wr,
    input logic [1:0]   csr_addr,
    input logic [31:0]  csr_wdata,
    input logic [N-1:0] status,
    input logic [N-1:0] en,
    input logic [W-1:0] limit,
    input logic         busy,
    input logic         irq
);
    logic [N-1:0] set_all;
    logic         st_write;
    always_comb begin
        set_all    = evt;
        set_all[6] = evt[6] | expire;
        st_write   = csr_wr && (csr_addr == 2'd0);
    end

    assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> ((status & $past(set_all)) == $past(set_all)));

    assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !st_write) |=> ((status & $past(status)) == $past(status)));

    assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_write && !soft_rst) |=>
            ((status & $past(csr_wdata[N-1:0] & ~set_all)) == '0));

    assert_irq_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> (irq == |($past(status & en))));

    assert_wd_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |=> !busy);

    assert_done_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt[6] |=> !busy);

    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (status == '0 && en == '0 && !busy && !irq));
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.N(17), .W(WDOG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .evt(evt_i),
    .expire(wd_expire), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .status(status_q), .en(en_q),
    .limit(limit_q), .busy(wd_busy), .irq(irq_o)
);

// File: tb/dma_irq_ctrl_test.sv
`timescale 1ns/100ps
module dma_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [16:0] evt_i = '0;
    logic        rx_frame_i = 1'b0;
    logic        csr_wr = 1'b0;
    logic [1:0]  csr_addr = 2'd0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    localparam logic [31:0] MASK17 = 32'h0001_FFFF;

    always #2.5 clk = ~clk;

    dma_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .evt_i(evt_i),
        .rx_frame_i(rx_frame_i), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_o(irq_o)
    );

    task automatic report();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cycles);
            report();
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        csr_addr = a;
        #0.2;
        d = csr_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
        tick();
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic pulse_evt(input logic [16:0] v);
        evt_i = v;
        tick();
        evt_i = '0;
    endtask

    task automatic pulse_frame();
        rx_frame_i = 1'b1;
        tick();
        rx_frame_i = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // Reset state
        rd(2'd0, d); chk("R1 reset status", d, 32'h0);
        rd(2'd1, d); chk("R4 reset enable", d, 32'h0);
        chk("R5 reset irq", {31'h0, irq_o}, 32'h0);

        // R10 map readback
        wr(2'd2, 32'h1234_5605);
        rd(2'd2, d); chk("R10 reload readback", d, 32'h05);
        rd(2'd3, d); chk("R10 reserved reads zero", d, 32'h0);
        wr(2'd2, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); chk("R4 enable masked", d, MASK17);

        // Sweep every status bit
        for (int k = 0; k < 17; k++) begin
            logic [31:0] b;
            b = 32'h1 << k;
            wr(2'd1, b);
            pulse_evt(b[16:0]);
            rd(2'd0, d); chk("R1 event sets bit", d, b);
            chk("R5 irq not yet", {31'h0, irq_o}, 32'h0);
            tick();
            chk("R5 irq raised", {31'h0, irq_o}, 32'h1);
            rd(2'd0, d); rd(2'd0, d); chk("R1 sticky after reads", d, b);
            wr(2'd0, ~b);
            rd(2'd0, d); chk("R2 zero bits keep status", d, b);
            evt_i = b[16:0]; csr_addr = 2'd0; csr_wdata = b; csr_wr = 1'b1;
            tick();
            evt_i = '0; csr_wr = 1'b0;
            rd(2'd0, d); chk("R3 set beats clear", d, b);
            wr(2'd0, b);
            rd(2'd0, d); chk("R2 write one clears", d, 32'h0);
            tick();
            chk("R5 irq drops", {31'h0, irq_o}, 32'h0);
            wr(2'd1, MASK17 & ~b);
            pulse_evt(b[16:0]);
            repeat (2) tick();
            chk("R5 masked bit no irq", {31'h0, irq_o}, 32'h0);
            wr(2'd0, 32'hFFFF_FFFF);
        end

        // R6 countdown sweep
        wr(2'd1, 32'h0);
        for (int n = 1; n <= 6; n++) begin
            wr(2'd2, n);
            pulse_frame();
            for (int k = 1; k <= n + 1; k++) begin
                tick();
                rd(2'd0, d);
                chk("R6 expiry timing", {31'h0, d[6]}, {31'h0, (k == n + 1)});
            end
            wr(2'd0, 32'h40);
        end

        // R7 zero reload disables
        wr(2'd2, 32'h0);
        pulse_frame();
        repeat (20) tick();
        rd(2'd0, d); chk("R7 disabled no expiry", d, 32'h0);

        // R8 done event cancels
        wr(2'd2, 32'd5);
        pulse_frame();
        tick();
        pulse_evt(17'h40);
        wr(2'd0, 32'h40);
        repeat (10) tick();
        rd(2'd0, d); chk("R8 cancelled countdown", d, 32'h0);

        // R11 restart
        wr(2'd2, 32'd4);
        pulse_frame();
        tick(); tick();
        pulse_frame();
        for (int k = 1; k <= 5; k++) begin
            tick();
            rd(2'd0, d);
            chk("R11 restart timing", {31'h0, d[6]}, {31'h0, (k == 5)});
        end
        wr(2'd0, 32'h40);

        // R9 soft reset
        wr(2'd1, MASK17);
        wr(2'd2, 32'd3);
        pulse_frame();
        pulse_evt(17'h1_0005);
        tick();
        chk("R9 irq before soft reset", {31'h0, irq_o}, 32'h1);
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
        rd(2'd0, d); chk("R9 status cleared", d, 32'h0);
        rd(2'd1, d); chk("R9 enable cleared", d, 32'h0);
        rd(2'd2, d); chk("R9 reload kept", d, 32'h3);
        chk("R9 irq cleared", {31'h0, irq_o}, 32'h0);
        repeat (8) tick();
        rd(2'd0, d); chk("R9 countdown stopped", d, 32'h0);

        done = 1'b1;
        report();
    end
endmodule